// File: doc/BRIEF.md
# Lane-Indexed Saturating Doubling Multiply-High Unit

This SIMD datapath multiplies every signed lane of a 128-bit operand A by one signed lane taken from a 128-bit operand B and broadcast to all lanes. For each lane it doubles the full-precision product and keeps the upper half, with truncation or with rounding. It then clamps the value to the signed range of the lane width. Lanes are 16 or 32 bits wide. The unit works either on a whole vector (64 or 128 bits) or on a single scalar lane. The broadcast lane is chosen by three index bits, and how those bits are read depends on the lane width.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream through one output register, one clock after acceptance. The unit accepts a new operation whenever its output register is empty, or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, every output of the beat holds still and no new operation is taken. Each beat carries a flag showing that a lane was clamped. A sticky flag gathers these events until software clears it with `sat_clear`. An illegal size code produces a beat that carries only an undefined-encoding flag.

Top module: `dmh_mulhi_unit`

## Requirements
- R1: `size_code` 01 selects 16-bit lanes and 10 selects 32-bit lanes. Codes 00 and 11 produce a beat with `undef_enc`=1 and `sat_any`=0. On that beat `res` keeps its previous value and `sat_sticky` is not set.
- R2: With 16-bit lanes the broadcast lane of B is lane k = {idx_h,idx_l,idx_m}, found at bits [16k+15:16k].
- R3: With 32-bit lanes the broadcast lane is k = {idx_h,idx_l}, found at bits [32k+31:32k]. `idx_m` has no effect on the result.
- R4: In vector mode (`vec_mode`=1) with `wide_q`=0, only the low 64 bits of A are processed and `res[127:64]` is zero. With `wide_q`=1, all 128 bits are processed.
- R5: In scalar mode (`vec_mode`=0) only lane 0 is processed, and every result bit above that lane is zero.
- R6: Each result lane equals (2·a·b + (rnd_en ? 2^(EW-1) : 0)) shifted arithmetically right by EW, where EW is the lane width and a, b are signed.
- R7: When a shifted value leaves the signed EW-bit range, the lane is clamped. In practice this happens only when a and b are both the most negative value, and the lane then becomes the most positive value. `sat_any` is 1 on exactly those beats where an active lane clamped.
- R8: `sat_sticky` resets to 0. It becomes 1 at the acceptance of an operation that clamps and stays 1 until `sat_clear` is high at a clock edge. A clamping acceptance wins over a clear in the same cycle.
- R9: An operation accepted at an edge is presented with `out_valid`=1 after that edge. `in_ready` equals `!out_valid || out_ready`. While the beat is stalled, `res`, `sat_any` and `undef_enc` stay stable.
- R10: After reset `out_valid`, `res`, `sat_any`, `undef_enc` and `sat_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on inputs |
| in_ready | output | 1 | Unit can accept an operation |
| opa | input | 128 | Multiplicand vector A |
| opb | input | 128 | Source of the broadcast lane B |
| size_code | input | 2 | Lane width code (01=16, 10=32) |
| vec_mode | input | 1 | 1 = vector, 0 = scalar |
| wide_q | input | 1 | Vector width: 0 = 64 bits, 1 = 128 bits |
| idx_h | input | 1 | Index bit H |
| idx_l | input | 1 | Index bit L |
| idx_m | input | 1 | Index bit M (16-bit lanes only) |
| rnd_en | input | 1 | Add half before shifting |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| res | output | 128 | Result lanes |
| sat_any | output | 1 | A lane of this beat clamped |
| undef_enc | output | 1 | This beat had an illegal size code |
| sat_clear | input | 1 | Clear the sticky flag |
| sat_sticky | output | 1 | Cumulative clamp flag |

## Verification
The bound checker watches the stream handshake on every cycle. It checks the one-clock latency, that a stalled beat holds still, and that `in_ready` follows `out_valid` and `out_ready`. It also checks the zero upper bits in scalar and 64-bit modes, that an illegal code leaves `res` untouched, and that the sticky flag holds and is set alongside a clamping beat. The arithmetic values can only be shown by the bench scenarios, which check them against a wide-integer model. These scenarios sweep every index in both lane widths, include the both-minimum corner under both rounding modes, and apply back-pressure and a clear in the same cycle as a clamp.

// File: rtl/dmh_pkg.sv
package dmh_pkg;
  localparam int VEC_W = 128;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_RSV_HI = 2'b11
  } lane_size_e;
endpackage

// File: rtl/dmh_lane.sv
module dmh_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic          rnd,
  output logic [EW-1:0] q,
  output logic          sat
);
  localparam int PW = 2 * EW + 2;

  logic signed [PW-1:0] pa, pb, prod, bias, sum, shr;
  logic [PW-EW:0] top_bits;

  always_comb begin
    pa   = {{(PW-EW){a[EW-1]}}, a};
    pb   = {{(PW-EW){b[EW-1]}}, b};
    prod = (pa * pb) <<< 1;
    bias = rnd ? (PW'(1) <<< (EW - 1)) : '0;
    sum  = prod + bias;
    shr  = sum >>> EW;
    top_bits = shr[PW-1:EW-1];
    sat = !((&top_bits) || (~|top_bits));
    if (sat) q = shr[PW-1] ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
    else     q = shr[EW-1:0];
  end
endmodule

// File: rtl/dmh_bank.sv
module dmh_bank #(
  parameter int VW = 128,
  parameter int EW = 16
) (
  input  logic [VW-1:0]    va,
  input  logic [EW-1:0]    bsel,
  input  logic             rnd,
  input  logic [VW/EW-1:0] en,
  output logic [VW-1:0]    vq,
  output logic             sat
);
  localparam int NL = VW / EW;

  logic [NL-1:0] lane_sat;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [EW-1:0] lq;
    logic          ls;
    dmh_lane #(.EW(EW)) u_lane (
      .a  (va[g*EW +: EW]),
      .b  (bsel),
      .rnd(rnd),
      .q  (lq),
      .sat(ls)
    );
    assign vq[g*EW +: EW] = en[g] ? lq : '0;
    assign lane_sat[g]    = en[g] & ls;
  end

  assign sat = |lane_sat;
endmodule

// File: rtl/dmh_mulhi_unit.sv
module dmh_mulhi_unit
  import dmh_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] opa,
  input  logic [127:0] opb,
  input  logic [1:0]   size_code,
  input  logic         vec_mode,
  input  logic         wide_q,
  input  logic         idx_h,
  input  logic         idx_l,
  input  logic         idx_m,
  input  logic         rnd_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] res,
  output logic         sat_any,
  output logic         undef_enc,
  input  logic         sat_clear,
  output logic         sat_sticky
);
  localparam int NL_H = VEC_W / HALF_W;
  localparam int NL_W = VEC_W / WORD_W;

  logic [2:0]         idx_half;
  logic [1:0]         idx_word;
  logic [HALF_W-1:0]  b_half;
  logic [WORD_W-1:0]  b_word;
  logic [NL_H-1:0]    en_half;
  logic [NL_W-1:0]    en_word;
  logic [VEC_W-1:0]   q_half, q_word, q_sel;
  logic               s_half, s_word, s_sel;
  logic               legal, accept;
  lane_size_e         sz;

  assign sz       = lane_size_e'(size_code);
  assign idx_half = {idx_h, idx_l, idx_m};
  assign idx_word = {idx_h, idx_l};
  assign b_half   = opb[idx_half*HALF_W +: HALF_W];
  assign b_word   = opb[idx_word*WORD_W +: WORD_W];

  always_comb begin
    for (int g = 0; g < NL_H; g++)
      en_half[g] = vec_mode ? (wide_q || g < NL_H / 2) : (g == 0);
    for (int g = 0; g < NL_W; g++)
      en_word[g] = vec_mode ? (wide_q || g < NL_W / 2) : (g == 0);
  end

  dmh_bank #(.VW(VEC_W), .EW(HALF_W)) u_bank_half (
    .va(opa), .bsel(b_half), .rnd(rnd_en), .en(en_half), .vq(q_half), .sat(s_half)
  );

  dmh_bank #(.VW(VEC_W), .EW(WORD_W)) u_bank_word (
    .va(opa), .bsel(b_word), .rnd(rnd_en), .en(en_word), .vq(q_word), .sat(s_word)
  );

  always_comb begin
    legal = 1'b1;
    q_sel = q_half;
    s_sel = s_half;
    case (sz)
      SZ_HALF: begin q_sel = q_half; s_sel = s_half; end
      SZ_WORD: begin q_sel = q_word; s_sel = s_word; end
      default: begin legal = 1'b0; q_sel = '0; s_sel = 1'b0; end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      sat_any   <= 1'b0;
      undef_enc <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      undef_enc <= !legal;
      sat_any   <= legal && s_sel;
      if (legal) res <= q_sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_sticky <= 1'b0;
    else        sat_sticky <= (sat_sticky && !sat_clear) || (accept && legal && s_sel);
  end
endmodule

// File: rtl/dmh_mulhi_chk.sv
module dmh_mulhi_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   size_code,
  input logic         vec_mode,
  input logic         wide_q,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] res,
  input logic         sat_any,
  input logic         undef_enc,
  input logic         sat_clear,
  input logic         sat_sticky
);
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(sat_any) && $stable(undef_enc));

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  a_r1_undef_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (size_code == 2'b00 || size_code == 2'b11)
    |=> undef_enc && !sat_any && $stable(res));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && vec_mode && !wide_q && (size_code == 2'b01 || size_code == 2'b10)
    |=> res[127:64] == '0);

  a_r5_scalar_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !vec_mode && size_code == 2'b01 |=> res[127:16] == '0);

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clear |=> sat_sticky);

  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> (!sat_any || sat_sticky));

  a_r7_no_sat_undef: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && undef_enc |-> !sat_any);
endmodule

bind dmh_mulhi_unit dmh_mulhi_chk u_chk (.*);

// File: tb/dmh_mulhi_unit_bench.sv
module dmh_mulhi_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [127:0] opa = '0, opb = '0, res;
  logic [1:0] size_code = 2'b01;
  logic vec_mode = 1'b1, wide_q = 1'b1, idx_h = 1'b0, idx_l = 1'b0, idx_m = 1'b0, rnd_en = 1'b0;
  logic sat_any, undef_enc, sat_clear = 1'b0, sat_sticky;

  int checks = 0, errors = 0;
  string cur_tag = "R6";

  typedef struct { logic [127:0] r; bit s; bit u; string tag; } exp_t;
  exp_t expq[$];
  logic [127:0] last_res_m = '0;
  bit sticky_m = 1'b0;

  always #5 clk = ~clk;

  dmh_mulhi_unit u_dmh_mulhi_unit (.*);

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(output logic [127:0] r, output bit s);
    int ew, n, idx;
    logic [31:0] bl, al;
    logic signed [79:0] ea, eb, p, maxv, minv;
    ew = (size_code == 2'b01) ? 16 : 32;
    n = vec_mode ? ((wide_q ? 128 : 64) / ew) : 1;
    idx = (ew == 16) ? int'({idx_h, idx_l, idx_m}) : int'({idx_h, idx_l});
    bl = (ew == 16) ? {16'b0, opb[idx*16 +: 16]} : opb[idx*32 +: 32];
    r = '0; s = 1'b0;
    for (int e = 0; e < n; e++) begin
      al = (ew == 16) ? {16'b0, opa[e*16 +: 16]} : opa[e*32 +: 32];
      ea = (ew == 16) ? 80'(signed'(al[15:0])) : 80'(signed'(al));
      eb = (ew == 16) ? 80'(signed'(bl[15:0])) : 80'(signed'(bl));
      p = 2 * ea * eb + (rnd_en ? (80'sd1 <<< (ew - 1)) : 80'sd0);
      p = p >>> ew;
      maxv = (80'sd1 <<< (ew - 1)) - 80'sd1;
      minv = -(80'sd1 <<< (ew - 1));
      if (p > maxv) begin p = maxv; s = 1'b1; end
      if (p < minv) begin p = minv; s = 1'b1; end
      if (ew == 16) r[e*16 +: 16] = p[15:0];
      else          r[e*32 +: 32] = p[31:0];
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] mr;
      bit ms, leg, acc;
      exp_t x;
      chk(sat_sticky == sticky_m, "R8 sticky", 128'(sat_sticky), 128'(sticky_m));
      chk(out_valid == (expq.size() != 0), "R9 out_valid", 128'(out_valid), 128'(expq.size() != 0));
      chk(in_ready == (!out_valid || out_ready), "R9 in_ready", 128'(in_ready), 128'(!out_valid || out_ready));
      if (out_valid && out_ready && expq.size() != 0) begin
        x = expq.pop_front();
        chk(res == x.r, {x.tag, " res"}, res, x.r);
        chk(sat_any == x.s, {x.tag, " sat_any R7"}, 128'(sat_any), 128'(x.s));
        chk(undef_enc == x.u, {x.tag, " undef R1"}, 128'(undef_enc), 128'(x.u));
      end
      acc = in_valid && in_ready;
      leg = (size_code == 2'b01 || size_code == 2'b10);
      ms = 1'b0;
      if (acc) begin
        if (leg) begin model(mr, ms); last_res_m = mr; end
        x.r = last_res_m; x.s = ms; x.u = !leg; x.tag = cur_tag;
        expq.push_back(x);
      end
      sticky_m = (sticky_m && !sat_clear) || (acc && leg && ms);
    end
  end

  task automatic send(logic [127:0] a, logic [127:0] b, logic [1:0] sz, bit vec, bit q,
                      logic [2:0] hlm, bit rnd, string tag);
    bit r;
    @(posedge clk); #1;
    opa = a; opb = b; size_code = sz; vec_mode = vec; wide_q = q;
    {idx_h, idx_l, idx_m} = hlm; rnd_en = rnd; cur_tag = tag; in_valid = 1'b1;
    forever begin
      @(negedge clk); r = in_ready;
      @(posedge clk);
      if (r) break;
    end
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && res == '0 && !sat_any && !undef_enc && !sat_sticky, "R10 reset",
        {out_valid, sat_any, undef_enc, sat_sticky}, '0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R6 both rounding modes, 16 and 32 bit
    send(rnd128(), rnd128(), 2'b01, 1, 1, 3'd5, 0, "R6 trunc h");
    send(rnd128(), rnd128(), 2'b01, 1, 1, 3'd5, 1, "R6 round h");
    send(rnd128(), rnd128(), 2'b10, 1, 1, 3'd2, 0, "R6 trunc s");
    send(rnd128(), rnd128(), 2'b10, 1, 1, 3'd2, 1, "R6 round s");
    // R2 every 16-bit index
    for (int k = 0; k < 8; k++) send(rnd128(), rnd128(), 2'b01, 1, 1, 3'(k), 0, "R2 index");
    // R3 every 32-bit index, M toggled
    for (int k = 0; k < 8; k++) send(rnd128(), rnd128(), 2'b10, 1, 1, 3'(k), k[0], "R3 index");
    // R4 half width
    send(rnd128(), rnd128(), 2'b01, 1, 0, 3'd7, 0, "R4 64b h");
    send(rnd128(), rnd128(), 2'b10, 1, 0, 3'd6, 1, "R4 64b s");
    // R5 scalar
    send(rnd128(), rnd128(), 2'b01, 0, 1, 3'd3, 1, "R5 scalar h");
    send(rnd128(), rnd128(), 2'b10, 0, 0, 3'd1, 0, "R5 scalar s");
    // R7 both minimum
    send({8{16'h8000}}, {8{16'h8000}}, 2'b01, 1, 1, 3'd4, 0, "R7 min h trunc");
    send({8{16'h8000}}, {8{16'h8000}}, 2'b01, 1, 1, 3'd0, 1, "R7 min h round");
    send({4{32'h80000000}}, {4{32'h80000000}}, 2'b10, 1, 1, 3'd3, 0, "R7 min s");
    send({4{32'h80000000}}, {4{32'h7fffffff}}, 2'b10, 1, 1, 3'd1, 1, "R7 near s");
    // R8 sticky persists over a clean op, then clear
    send(128'h1, 128'h1, 2'b01, 1, 1, 3'd0, 0, "R8 clean");
    @(posedge clk); #1 sat_clear = 1'b1;
    @(posedge clk); #1 sat_clear = 1'b0;
    // R8 clear and clamp together: set wins
    #0 sat_clear = 1'b1;
    send({8{16'h8000}}, {8{16'h8000}}, 2'b01, 0, 0, 3'd0, 0, "R8 clear+set");
    sat_clear = 1'b0;
    // R1 illegal codes
    send(rnd128(), rnd128(), 2'b00, 1, 1, 3'd0, 0, "R1 code00");
    send({8{16'h8000}}, {8{16'h8000}}, 2'b11, 1, 1, 3'd0, 0, "R1 code11");
    send(rnd128(), rnd128(), 2'b01, 1, 1, 3'd2, 0, "R1 legal after");
    // R9 back-pressure
    @(posedge clk); #1 out_ready = 1'b0;
    fork
      send(rnd128(), rnd128(), 2'b10, 1, 1, 3'd0, 0, "R9 stall a");
      begin repeat (6) @(posedge clk); #1 out_ready = 1'b1; end
    join
    send(rnd128(), rnd128(), 2'b01, 1, 1, 3'd1, 1, "R9 stall b");
    // mixed random
    for (int k = 0; k < 60; k++) begin
      if (k % 7 == 3) begin @(posedge clk); #1 out_ready = 1'b0; end
      else begin @(posedge clk); #1 out_ready = 1'b1; end
      fork
        send(($urandom % 4 == 0) ? {8{16'h8000}} : rnd128(),
             ($urandom % 4 == 0) ? {8{16'h8000}} : rnd128(),
             2'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), "R6 random");
        begin repeat (2) @(posedge clk); #1 out_ready = 1'b1; end
      join
    end
    repeat (4) @(posedge clk);
    chk(expq.size() == 0, "R9 drained", 128'(expq.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule